// File: doc/BRIEF.md
# Boot Supervision Watchdog

This block is a byte-wide watchdog that a board controller uses to supervise early boot. Software programs a reload value in whole seconds and enables the timer. It must then rewrite a fixed magic byte before the count runs out. A missed deadline is a bite. Depending on the control bits, a bite pulses a board reset request, pulls an active-low timeout pin low, and sets a sticky flag that tells the next boot to take the failsafe loader.

There are three byte registers on a simple synchronous bus: control, reload and kick. A write is one cycle with `busWrEn` high. Reads are combinational from `busAddr`. The countdown advances once per second tick. The tick comes from an internal prescaler on the clock or from an external one-cycle pulse, chosen by a pin. A lock bit freezes the configuration until the next reset, so a locked watchdog cannot be turned off by software.

Top module: `boot_watchdog`

## Requirements
- R1: The control register is at address 0, the reload register at 1 and the kick register at 2. The control register stores only bits 0, 1, 2, 6 and 7; the other bits read back as 0. The reload register reads back as written, and the kick register always reads 0x00.
- R2: After reset, control and reload read 0x00, `sysResetReq` is 0, `timeoutPinN` is 1 and `failsafeBoot` is 0.
- R3: Writing 0x6B to the kick register loads the countdown with the reload value and restarts the current second. Writing any other value to the kick register has no effect on the countdown.
- R4: While control bit 0 (normal) or bit 1 (recovery) is set, the countdown decreases by one per second tick. A bite occurs once it has reached zero, so a reload of N bites after N ticks.
- R5: With both enable bits clear, the countdown holds and no bite occurs.
- R6: A reload of 0, then a kick, then an enable write causes a bite on the next clock edge after the enable write.
- R7: If control bit 6 is set at the bite, `sysResetReq` is high for exactly 16 consecutive cycles, once.
- R8: If control bit 7 is set at the bite, `timeoutPinN` goes low and stays low until reset.
- R9: If the recovery enable (bit 1) is set at the bite, `failsafeBoot` becomes 1 and stays 1 until reset. A bite under the normal enable alone leaves it at 0.
- R10: Once control bit 2 (lock) is set, writes to control and reload are ignored until reset, so the enables cannot be cleared. Kicks still work.
- R11: With `selExtTick` high, the countdown advances only on `extTick` pulses and not on the internal prescaler.
- R12: A bite with bits 6, 7 and 1 all clear leaves all three outputs at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears everything including the lock |
| busWrEn | input | 1 | One-cycle register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| selExtTick | input | 1 | 1 selects `extTick` as the second tick |
| extTick | input | 1 | External one-cycle second pulse |
| sysResetReq | output | 1 | Board reset request pulse |
| timeoutPinN | output | 1 | Active-low timeout indication |
| failsafeBoot | output | 1 | Sticky request to boot the failsafe loader |

## Verification
The hardest state to reach is a locked watchdog, because the block only leaves it through reset. Each scenario therefore starts from its own reset. The lock scenario tries to clear the enables and rewrite the reload, then reads both registers back and waits for the bite it could not prevent. A second hard case is telling a real kick from a near-miss value. The bench runs the same kick cadence with 0x6B and with 0x6A, and only the first may hold the timeout pin high. Both the reset pulse and the failsafe flag are checked from the timeout-0 forced bite, with the pulse high cycles counted one by one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KICK   = 2'd2;

  localparam logic [DATA_W-1:0] KICK_MAGIC = 8'h6B;
  localparam logic [DATA_W-1:0] CTRL_MASK  = 8'hC7;

  localparam int BIT_EN_NORM  = 0;
  localparam int BIT_EN_RECOV = 1;
  localparam int BIT_LOCK     = 2;
  localparam int BIT_ACT_RST  = 6;
  localparam int BIT_ACT_PIN  = 7;

  typedef struct packed {
    logic              kick;
    logic              enNorm;
    logic              enRecov;
    logic              actReset;
    logic              actPin;
    logic [DATA_W-1:0] reload;
  } wdgStrobes_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output wdgStrobes_t       strobes
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] reloadReg;
  logic              lockBit;

  assign lockBit = ctrlReg[BIT_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg   <= '0;
      reloadReg <= '0;
    end else if (wrEn && !lockBit) begin
      if (addr == ADDR_CTRL)   ctrlReg   <= wdata & CTRL_MASK;
      if (addr == ADDR_RELOAD) reloadReg <= wdata;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdata = ctrlReg;
      ADDR_RELOAD: rdata = reloadReg;
      default:     rdata = '0;
    endcase
  end

  always_comb begin
    strobes.kick     = wrEn && (addr == ADDR_KICK) && (wdata == KICK_MAGIC);
    strobes.enNorm   = ctrlReg[BIT_EN_NORM];
    strobes.enRecov  = ctrlReg[BIT_EN_RECOV];
    strobes.actReset = ctrlReg[BIT_ACT_RST];
    strobes.actPin   = ctrlReg[BIT_ACT_PIN];
    strobes.reload   = reloadReg;
  end

  // R10: a set lock freezes both configuration registers
  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lockBit |=> (lockBit && $stable(ctrlReg) && $stable(reloadReg)));

  // R1: unimplemented control bits never hold a one
  assert_ctrl_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlReg & ~CTRL_MASK) == '0);
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CLKS_PER_SEC = 25_000_000,
  parameter int PULSE_LEN    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        selExtTick,
  input  logic        extTick,
  input  wdgStrobes_t strobes,
  output logic        sysResetReq,
  output logic        timeoutPinN,
  output logic        failsafeBoot
);
  localparam int PRE_W   = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic               enabled;
  logic               running;
  logic               intTick;
  logic               secTick;
  logic               fire;
  logic               expiredQ;
  logic               pinLowQ;
  logic [DATA_W-1:0]  count;
  logic [PULSE_W-1:0] pulseCnt;

  assign enabled = strobes.enNorm || strobes.enRecov;
  assign running = enabled && !expiredQ;

  generate
    if (CLKS_PER_SEC <= 1) begin : g_noPresc
      assign intTick = 1'b1;
    end else begin : g_presc
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) preCnt <= '0;
        else if (strobes.kick || !running) preCnt <= '0;
        else if (preCnt == PRE_W'(CLKS_PER_SEC - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign intTick = running && (preCnt == PRE_W'(CLKS_PER_SEC - 1));
    end
  endgenerate

  assign secTick = selExtTick ? extTick : intTick;
  assign fire    = running && (count == '0) && !strobes.kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (strobes.kick) count <= strobes.reload;
    else if (running && secTick && (count != '0)) count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expiredQ     <= 1'b0;
      pinLowQ      <= 1'b0;
      failsafeBoot <= 1'b0;
      pulseCnt     <= '0;
    end else if (fire) begin
      expiredQ     <= 1'b1;
      pinLowQ      <= strobes.actPin;
      failsafeBoot <= strobes.enRecov;
      pulseCnt     <= strobes.actReset ? PULSE_W'(PULSE_LEN) : '0;
    end else if (pulseCnt != '0) begin
      pulseCnt     <= pulseCnt - 1'b1;
    end
  end

  assign sysResetReq = (pulseCnt != '0);
  assign timeoutPinN = !pinLowQ;

  // R4: the count only moves down by one between kicks
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.kick |=> (count == $past(count) || count == $past(count) - 1'b1));

  // R5: with both enables clear the count holds
  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !strobes.kick) |=> $stable(count));

  // R6: an enabled zero count bites on the next edge
  assert_zero_bites_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count == '0 && !strobes.kick) |=> expiredQ);

  // R7: reset request only exists after a bite
  assert_pulse_after_bite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |-> expiredQ);

  // R8: the timeout pin stays low once pulled low
  assert_pin_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !timeoutPinN |=> !timeoutPinN);

  // R9: the failsafe request is sticky
  assert_failsafe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    failsafeBoot |=> failsafeBoot);
endmodule

// File: rtl/boot_watchdog.sv
module boot_watchdog
  import wdg_pkg::*;
#(
  parameter int CLKS_PER_SEC = 25_000_000,
  parameter int PULSE_LEN    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              selExtTick,
  input  logic              extTick,
  output logic              sysResetReq,
  output logic              timeoutPinN,
  output logic              failsafeBoot
);
  wdgStrobes_t strobes;

  wdg_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (busWrEn),
    .addr    (busAddr),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .strobes (strobes)
  );

  wdg_datapath #(
    .CLKS_PER_SEC (CLKS_PER_SEC),
    .PULSE_LEN    (PULSE_LEN)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .selExtTick   (selExtTick),
    .extTick      (extTick),
    .strobes      (strobes),
    .sysResetReq  (sysResetReq),
    .timeoutPinN  (timeoutPinN),
    .failsafeBoot (failsafeBoot)
  );
endmodule

// File: tb/boot_watchdog_tb.sv
module boot_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPS        = 8;
  localparam int PULSE      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       selExtTick = 1'b0;
  logic       extTick = 1'b0;
  logic       sysResetReq, timeoutPinN, failsafeBoot;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_watchdog #(.CLKS_PER_SEC(CPS), .PULSE_LEN(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .selExtTick(selExtTick),
    .extTick(extTick), .sysResetReq(sysResetReq), .timeoutPinN(timeoutPinN),
    .failsafeBoot(failsafeBoot)
  );

  typedef struct packed {
    logic [1:0] wa;
    logic [7:0] wd;
    logic [1:0] ra;
    logic [7:0] exp;
  } vec_t;

  // R1 register map vectors, enables kept clear
  localparam vec_t VECS [6] = '{
    '{2'd0, 8'hF8, 2'd0, 8'hC0},
    '{2'd0, 8'h40, 2'd0, 8'h40},
    '{2'd1, 8'hA5, 2'd1, 8'hA5},
    '{2'd2, 8'h6B, 2'd2, 8'h00},
    '{2'd2, 8'h12, 2'd1, 8'hA5},
    '{2'd1, 8'hFF, 2'd0, 8'h40}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; selExtTick = 1'b0; extTick = 1'b0;
    wait_cycles(2);
    rst_n = 1'b1;
    wait_cycles(1);
  endtask

  task automatic arm(input logic [7:0] reload, input logic [7:0] ctrl);
    wr(2'd0, 8'h00);
    wr(2'd1, reload);
    wr(2'd2, 8'h6B);
    wr(2'd0, ctrl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int hi;
    do_reset();

    // R2 reset state
    rd(2'd0, r); check("R2 ctrl", r, 8'h00);
    rd(2'd1, r); check("R2 reload", r, 8'h00);
    check("R2 sysResetReq", sysResetReq, 0);
    check("R2 timeoutPinN", timeoutPinN, 1);
    check("R2 failsafeBoot", failsafeBoot, 0);

    // R1 vector table
    foreach (VECS[i]) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, r);
      check($sformatf("R1 vec%0d", i), r, VECS[i].exp);
    end

    // R4 countdown of 3 seconds with pin action
    do_reset();
    arm(8'd3, 8'h81);
    wait_cycles(2*CPS);
    check("R4 before deadline", timeoutPinN, 1);
    wait_cycles(2*CPS);
    check("R4 after deadline", timeoutPinN, 0);
    check("R9 normal only no failsafe", failsafeBoot, 0);

    // R3 good kicks keep it alive
    do_reset();
    arm(8'd2, 8'h81);
    for (int k = 0; k < 6; k++) begin
      wait_cycles(CPS);
      wr(2'd2, 8'h6B);
    end
    check("R3 kicked alive", timeoutPinN, 1);
    wait_cycles(4*CPS);
    check("R3 bite after kicks stop", timeoutPinN, 0);

    // R3 wrong kick value ignored
    do_reset();
    arm(8'd2, 8'h81);
    for (int k = 0; k < 6; k++) begin
      wait_cycles(CPS);
      wr(2'd2, 8'h6A);
    end
    check("R3 bad kick ignored", timeoutPinN, 0);

    // R6 R7 R9 forced bite with recovery enable
    do_reset();
    arm(8'd0, 8'hC2);
    @(negedge clk);
    check("R6 immediate pin", timeoutPinN, 0);
    check("R9 failsafe set", failsafeBoot, 1);
    hi = sysResetReq ? 1 : 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (sysResetReq) hi++;
    end
    check("R7 pulse length", hi, PULSE);
    check("R8 pin still low", timeoutPinN, 0);
    check("R9 failsafe sticky", failsafeBoot, 1);

    // R12 bite with no actions
    do_reset();
    arm(8'd0, 8'h01);
    wait_cycles(20);
    check("R12 no reset", sysResetReq, 0);
    check("R12 pin idle", timeoutPinN, 1);
    check("R12 no failsafe", failsafeBoot, 0);

    // R5 disable stops the countdown
    do_reset();
    arm(8'd2, 8'h81);
    wait_cycles(CPS/2);
    wr(2'd0, 8'h80);
    wait_cycles(6*CPS);
    check("R5 stopped", timeoutPinN, 1);

    // R10 lock
    do_reset();
    arm(8'd5, 8'h85);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h09);
    rd(2'd0, r); check("R10 ctrl frozen", r, 8'h85);
    rd(2'd1, r); check("R10 reload frozen", r, 8'h05);
    wait_cycles(7*CPS);
    check("R10 still bites", timeoutPinN, 0);
    do_reset();
    rd(2'd0, r); check("R10 reset clears lock", r, 8'h00);

    // R11 external tick
    do_reset();
    selExtTick = 1'b1;
    arm(8'd2, 8'h81);
    wait_cycles(8*CPS);
    check("R11 no ext tick", timeoutPinN, 1);
    for (int t = 0; t < 2; t++) begin
      @(negedge clk); extTick = 1'b1;
      @(negedge clk); extTick = 1'b0;
    end
    wait_cycles(3);
    check("R11 ext ticks bite", timeoutPinN, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule